// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Detection

This block receives asynchronous serial characters on a single input line. The line is sampled sixteen times per bit, using an enable pulse that an external baud divider supplies. The receiver looks for a start bit and rejects starts caused by noise. It takes a three-sample vote near the middle of every data bit and of the stop bit. A mode input selects 8-bit or 9-bit characters. The receiver keeps the last character in a data register, and a fixed ninth-bit output carries the extra bit in 9-bit mode.

Software sees four status signals: receive-full, framing-error, break and reception-in-progress. Software clears the sticky flags with a read pair, modelled here as two one-cycle strobes: a status read, then a data read. The pair clears only the flags that were set when the status read happened. After a break has been reported and cleared, the break flag cannot set again until the line has been seen high. Without this rule, a line held low would report one break after another. The busy flag rises with the first low sample of a start search. It falls only when the start is judged false or when the line stays high for one full frame.

Top module: `uart_rx_brk`

## Requirements
- R1: In 8-bit mode a frame is one low start bit, then eight data bits least significant first, then a stop bit. Each data bit is the majority of oversample positions 7, 8 and 9 of its 16. The byte appears on `rdata` and `rx_full` rises when the stop bit is voted. The ninth-bit output `rx9` reads 0 in 8-bit mode.
- R2: `rx_busy` rises on the first enabled tick that sees the line low while the receiver searches for a start. It stays high through the character and after it.
- R3: If the majority of oversample positions 3, 5 and 7 of the start bit is high, the start is false. `rx_busy` falls, the receiver resumes the start search, and no character or flag is produced.
- R4: `rx_busy` falls once the line has stayed high for one frame length: 10 bit times in 8-bit mode, 11 in 9-bit mode.
- R5: A stop bit that votes low sets `frame_err` together with `rx_full`, and the data bits are still delivered.
- R6: A break is a frame whose data bits and stop bit all vote low. When break detection is armed, a break sets `brk_flag`, `frame_err` and `rx_full`, and `rdata` reads 0.
- R7: When `mode9` is 1, the frame carries nine data bits and the ninth bit appears on `rx9`. A break received in this mode drives `rx9` to 0.
- R8: A `data_rd` strobe clears each of `rx_full`, `frame_err` and `brk_flag` only if a `stat_rd` strobe earlier saw that flag set. A `data_rd` strobe with no status read before it leaves every flag unchanged.
- R9: After `brk_flag` sets, break detection stays disarmed until the flag is clear and the line has been seen high. A break that arrives while disarmed still sets `frame_err` and `rx_full` but not `brk_flag`.
- R10: Reset clears `rx_full`, `frame_err`, `brk_flag` and `rx_busy`. Reset leaves `rdata` and `rx9` as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversample enable, sixteen pulses per bit time |
| rxd | input | 1 | Serial line, idle high |
| mode9 | input | 1 | 1 selects nine data bits per character |
| stat_rd | input | 1 | One-cycle strobe: status register read |
| data_rd | input | 1 | One-cycle strobe: data register read |
| rdata | output | DBITS | Last received character (low bits) |
| rx9 | output | 1 | Ninth received bit, 0 in 8-bit mode |
| rx_full | output | 1 | Character available |
| frame_err | output | 1 | Stop bit voted low |
| brk_flag | output | 1 | Break character received |
| rx_busy | output | 1 | Reception in progress |

## Verification
The line passes through a two-flop synchronizer, so a level driven on `rxd` is seen by the first enable tick that comes at least two clocks later. The bench changes the line three clocks before each tick to stay inside that window. The character and its flags arrive on the clock edge of the tick at the stop bit's ninth oversample. The busy flag rises on the detection tick and falls on the seventh tick of a false start or on the last tick of an idle frame. Flags clear on the clock edge that samples the data-read strobe. The bench therefore reads results only after the enabling tick, or a whole bit time later, and never in the middle of a bit.

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             rxd,
  input  logic             mode9,
  input  logic             stat_rd,
  input  logic             data_rd,
  output logic [DBITS-1:0] rdata,
  output logic             rx9,
  output logic             rx_full,
  output logic             frame_err,
  output logic             brk_flag,
  output logic             rx_busy
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DBITS + 1);
  localparam int IW = $clog2((DBITS + 3) * OVS + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] C_V0 = CW'(OVS / 2 - 2);
  localparam logic [CW-1:0] C_V1 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] C_V2 = CW'(OVS / 2);
  localparam logic [CW-1:0] C_S0 = CW'(2);
  localparam logic [CW-1:0] C_S1 = CW'(4);
  localparam logic [CW-1:0] C_S2 = CW'(6);
  localparam logic [BW-1:0] LAST8 = BW'(DBITS - 1);
  localparam logic [BW-1:0] LAST9 = BW'(DBITS);
  localparam logic [IW-1:0] IDLE8 = IW'((DBITS + 2) * OVS);
  localparam logic [IW-1:0] IDLE9 = IW'((DBITS + 3) * OVS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t            state;
  logic           rx_m, rx_s;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bidx;
  logic [1:0]     vote;
  logic [DBITS:0] sh;
  logic [IW-1:0]  icnt;
  logic [2:0]     snap;
  logic           arm;

  wire maj      = (vote[1] & vote[0]) | (vote[1] & rx_s) | (vote[0] & rx_s);
  wire in_idle  = (state == S_IDLE);
  wire start_hit = tick16 & in_idle & ~rx_s;
  wire false_st = tick16 & (state == S_START) & (cnt == C_S2) & maj;
  wire done     = tick16 & (state == S_STOP) & (cnt == C_V2);
  wire ev_fe    = done & ~maj;
  wire ev_brk   = ev_fe & ~|sh & arm;
  wire [BW-1:0] last_idx = mode9 ? LAST9 : LAST8;
  wire [IW-1:0] idle_lim = mode9 ? IDLE9 : IDLE8;
  wire idle_hit = tick16 & in_idle & rx_s & (icnt == idle_lim - 1'b1);
  wire clr_full = data_rd & snap[2];
  wire clr_fe   = data_rd & snap[1];
  wire clr_brk  = data_rd & snap[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_s, rx_m} <= 2'b11;
    else        {rx_s, rx_m} <= {rx_m, rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      vote  <= '0;
      sh    <= '0;
    end else if (tick16) begin
      cnt <= cnt + 1'b1;
      case (state)
        S_IDLE: if (!rx_s) begin
          state <= S_START;
          cnt   <= CW'(1);
          sh    <= '0;
        end
        S_START: begin
          if (cnt == C_S0 || cnt == C_S1) vote <= {vote[0], rx_s};
          if (cnt == C_S2 && maj) state <= S_IDLE;
          else if (cnt == C_LAST) begin
            state <= S_DATA;
            cnt   <= '0;
            bidx  <= '0;
          end
        end
        S_DATA: begin
          if (cnt == C_V0 || cnt == C_V1) vote <= {vote[0], rx_s};
          if (cnt == C_V2) sh[bidx] <= maj;
          if (cnt == C_LAST) begin
            cnt <= '0;
            if (bidx == last_idx) state <= S_STOP;
            else bidx <= bidx + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt == C_V0 || cnt == C_V1) vote <= {vote[0], rx_s};
          if (cnt == C_V2) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) icnt <= '0;
    else if (!in_idle) icnt <= '0;
    else if (tick16) begin
      if (!rx_s) icnt <= '0;
      else if (icnt != idle_lim) icnt <= icnt + 1'b1;
    end

  always_ff @(posedge clk)
    if (done) begin
      rdata <= sh[DBITS-1:0];
      rx9   <= mode9 & sh[DBITS];
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full   <= 1'b0;
      frame_err <= 1'b0;
      brk_flag  <= 1'b0;
      rx_busy   <= 1'b0;
      snap      <= '0;
      arm       <= 1'b1;
    end else begin
      rx_full   <= done   | (rx_full & ~clr_full);
      frame_err <= ev_fe  | (frame_err & ~clr_fe);
      brk_flag  <= ev_brk | (brk_flag & ~clr_brk);
      if (start_hit) rx_busy <= 1'b1;
      else if (false_st || idle_hit) rx_busy <= 1'b0;
      if (data_rd) snap <= '0;
      else if (stat_rd) snap <= {rx_full, frame_err, brk_flag};
      if (ev_brk) arm <= 1'b0;
      else if (rx_s && !brk_flag) arm <= 1'b1;
    end
  end

  AST_BRK_WITH_FE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> (frame_err && rx_full)); // R6
  AST_BRK_NINTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> !rx9); // R7
  AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !data_rd) |=> brk_flag); // R8
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !data_rd) |=> rx_full); // R8
  AST_BUSY_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> !$past(rx_s)); // R2
  AST_BRK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(arm)); // R9
endmodule

// File: tb/sim_uart_rx_brk.sv
`timescale 1ns/1ps
module sim_uart_rx_brk;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1, mode9 = 1'b0;
  logic stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] rdata;
  logic rx9, rx_full, frame_err, brk_flag, rx_busy;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_rx_brk u0 (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .mode9(mode9),
    .stat_rd(stat_rd), .data_rd(data_rd), .rdata(rdata), .rx9(rx9), .rx_full(rx_full),
    .frame_err(frame_err), .brk_flag(brk_flag), .rx_busy(rx_busy));

  // {mode9, stop, data[8:0], exp_rdata[7:0], exp_rx9, exp_fe}
  localparam logic [20:0] VEC [7] = '{
    {1'b0, 1'b1, 9'h0A5, 8'hA5, 1'b0, 1'b0},
    {1'b0, 1'b1, 9'h13C, 8'h3C, 1'b0, 1'b0},
    {1'b0, 1'b0, 9'h0F0, 8'hF0, 1'b0, 1'b1},
    {1'b1, 1'b1, 9'h1C3, 8'hC3, 1'b1, 1'b0},
    {1'b1, 1'b1, 9'h055, 8'h55, 1'b0, 1'b0},
    {1'b0, 1'b1, 9'h0FF, 8'hFF, 1'b0, 1'b0},
    {1'b1, 1'b0, 9'h101, 8'h01, 1'b1, 1'b1}
  };

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tk();
    repeat (3) @(posedge clk);
    #1 tick16 = 1'b1;
    @(posedge clk);
    #1 tick16 = 1'b0;
  endtask

  task automatic drive(logic v, int n);
    rxd = v;
    repeat (n) tk();
  endtask

  task automatic frame(logic m9, logic [8:0] d, logic stp);
    mode9 = m9;
    drive(1'b0, 16);
    for (int i = 0; i < (m9 ? 9 : 8); i++) drive(d[i], 16);
    drive(stp, stp ? 16 : 9);
    rxd = 1'b1;
  endtask

  task automatic rd_pair();
    @(posedge clk); #1 stat_rd = 1'b1;
    @(posedge clk); #1 stat_rd = 1'b0; data_rd = 1'b1;
    @(posedge clk); #1 data_rd = 1'b0;
  endtask

  task automatic rd_data_only();
    @(posedge clk); #1 data_rd = 1'b1;
    @(posedge clk); #1 data_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R10 full after reset", rx_full, 0);
    check("R10 fe after reset", frame_err, 0);
    check("R10 brk after reset", brk_flag, 0);
    check("R10 busy after reset", rx_busy, 0);
    drive(1'b1, 32);

    // R1 R5 R7 R2 R8: table of characters
    foreach (VEC[k]) begin
      frame(VEC[k][20], VEC[k][18:10], VEC[k][19]);
      drive(1'b1, 32);
      check("R1 rdata", rdata, VEC[k][9:2]);
      check("R7 rx9", rx9, VEC[k][1]);
      check("R5 frame_err", frame_err, VEC[k][0]);
      check("R1 rx_full", rx_full, 1);
      check("R2 busy held", rx_busy, 1);
      rd_pair();
      check("R8 full cleared", rx_full, 0);
      check("R8 fe cleared", frame_err, 0);
    end

    // R6 R7: 9-bit break after rx9 was 1
    frame(1'b1, 9'h000, 1'b0);
    drive(1'b1, 16);
    check("R6 brk set", brk_flag, 1);
    check("R6 fe with brk", frame_err, 1);
    check("R6 full with brk", rx_full, 1);
    check("R6 rdata zero", rdata, 0);
    check("R7 break forces rx9 low", rx9, 0);
    rd_data_only();
    check("R8 data read alone keeps brk", brk_flag, 1);
    check("R8 data read alone keeps full", rx_full, 1);
    rd_pair();
    check("R8 pair clears brk", brk_flag, 0);

    // R9: line held low, second break not reported until line high
    mode9 = 1'b0;
    drive(1'b0, 200);
    check("R6 8-bit break sets brk", brk_flag, 1);
    rd_pair();
    check("R8 pair clears brk low line", brk_flag, 0);
    drive(1'b0, 106);
    drive(1'b1, 32);
    check("R9 disarmed break no brk", brk_flag, 0);
    check("R9 disarmed break fe", frame_err, 1);
    check("R9 disarmed break full", rx_full, 1);
    rd_pair();
    frame(1'b0, 9'h000, 1'b0);
    drive(1'b1, 16);
    check("R9 rearmed break sets brk", brk_flag, 1);
    rd_pair();
    drive(1'b1, 200);

    // R3: false start
    drive(1'b0, 1);
    check("R2 busy on first low", rx_busy, 1);
    drive(1'b0, 1);
    drive(1'b1, 12);
    check("R3 false start busy low", rx_busy, 0);
    check("R3 false start no char", rx_full, 0);
    drive(1'b1, 200);
    check("R3 still no char", rx_full, 0);

    // R4: idle frame drops busy
    frame(1'b0, 9'h012, 1'b1);
    drive(1'b1, 16);
    check("R4 busy before idle", rx_busy, 1);
    drive(1'b1, 160);
    check("R4 busy after idle", rx_busy, 0);
    rd_pair();

    // R10: reset retains data
    frame(1'b0, 9'h05A, 1'b1);
    drive(1'b1, 16);
    check("R1 rdata before reset", rdata, 9'h05A);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R10 rdata kept", rdata, 9'h05A);
    check("R10 full cleared", rx_full, 0);
    check("R10 busy cleared", rx_busy, 0);
    finish_run();
  end
endmodule